// File: doc/BRIEF.md
# Two-Wire Bus Segment Connection Controller

This block is the digital control core of a bidirectional buffer that sits between two I2C/SMBus segments, called the upstream side and the downstream side. It receives the SDA and SCL levels seen on both segments, a supply-good input, an enable input and a disconnect request from a separate stuck-bus detector. It drives active-high pull-down enables for the four bus lines and for an open-drain ready line.

With power good and enable high, the controller watches each segment on its own. It joins the two segments only when both have shown a STOP or a stretch of bus idle. While joined, a low that an outside device drives on one side of a line is copied to the same line on the other side. Each line records which side went low first, so the block's own pull-down is never mistaken for an outside driver. This keeps clock stretching, arbitration and ACK working across the boundary. Line inputs pass through synchronizers, and the pull-down and ready outputs are meant to drive open-drain pads.

Top module: `seg_link_ctrl`

## Requirements
- R1: While `pwr_good` is low, no line activity has any effect, and all five pull-down outputs (`up_sda_pd`, `up_scl_pd`, `dn_sda_pd`, `dn_scl_pd`, `rdy_pd`) are 0 within two clocks.
- R2: With `pwr_good` and `enable` high, the segments are joined only after each side has shown either a STOP (SDA rising while SCL stays high) or both lines high for `IDLE_CYCLES` consecutive synchronized cycles. A side that is held low is never counted as idle.
- R3: `rdy_pd` is 1 whenever power is good and the segments are not joined, and 0 while they are joined.
- R4: While `enable` is low, the block does not join the segments and drives no bus line. Dropping `enable` while joined releases every line and asserts `rdy_pd` within two clocks.
- R5: While joined, an outside low on any one line of one side makes the block pull the same line on the other side low within six clocks. It never pulls the side where the low came from, and the four lines behave alike.
- R6: When a low came from upstream and downstream is also being held by an outside device, the block releases downstream after upstream lets go. It then pulls upstream low again and holds it until downstream is free. Afterwards both wires end up high with no pull-down active.
- R7: Asserting `fault_disc` drops the connection within two clocks: no line pull-down stays active and `rdy_pd` is 1. The block joins again through the R2 rule once the request is removed.
- R8: After a copied low is released, the block's own pull-down, still visible through the synchronizer, does not start a new low. All pull-downs stay at 0 while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply above lockout threshold |
| enable | input | 1 | Allows the segments to be joined |
| fault_disc | input | 1 | Disconnect request from the stuck-bus detector |
| up_sda_i | input | 1 | Upstream SDA wire level |
| up_scl_i | input | 1 | Upstream SCL wire level |
| dn_sda_i | input | 1 | Downstream SDA wire level |
| dn_scl_i | input | 1 | Downstream SCL wire level |
| up_sda_pd | output | 1 | Pull upstream SDA low |
| up_scl_pd | output | 1 | Pull upstream SCL low |
| dn_sda_pd | output | 1 | Pull downstream SDA low |
| dn_scl_pd | output | 1 | Pull downstream SCL low |
| rdy_pd | output | 1 | Pull the ready line low (not joined) |

## Verification
The bench models each wire as the wired-AND of an outside driver and the block's own pull-down. It sweeps every line in both directions, so a relay that drove its source side, latched its own echoed low, or mixed up SDA and SCL shows up as a stuck or misplaced pull-down. Joining is tested both by the idle route and by a STOP that arrives well before the idle count. A controller that ignored STOP, or that counted a held-low side as idle, joins at the wrong time. The stretching case holds downstream SCL after upstream releases. A design without origin tracking would either leave upstream high while downstream is still held, or never release at all.

// File: rtl/seg_link_pkg.sv
package seg_link_pkg;

  // Per-line relay state: which side first drove the low
  typedef enum logic [1:0] {
    RL_FREE   = 2'd0,
    RL_UPLOW  = 2'd1,
    RL_DNLOW  = 2'd2,
    RL_SETTLE = 2'd3
  } relay_st_e;

  localparam int NUM_SIDES = 2;
  localparam int NUM_LINES = 2;

endpackage

// File: rtl/seg_sync.sv
module seg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '1;
          else        stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '1;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/seg_side_mon.sv
module seg_side_mon #(
  parameter int IDLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic sda,
  input  logic scl,
  output logic done
);

  localparam int CW = $clog2(IDLE_CYCLES + 1);

  logic          sda_prev_q, scl_prev_q;
  logic [CW-1:0] idle_cnt_q, idle_cnt_d;
  logic          done_q, done_d;
  logic          stop_seen, start_seen, idle_full, cnt_en;

  assign stop_seen  = scl && scl_prev_q && sda && !sda_prev_q;
  assign start_seen = scl && scl_prev_q && !sda && sda_prev_q;
  assign idle_full  = (idle_cnt_q == CW'(IDLE_CYCLES));
  assign cnt_en     = mon_en && sda && scl && !idle_full;

  always_comb begin
    idle_cnt_d = idle_cnt_q;
    if (!mon_en || !sda || !scl) idle_cnt_d = '0;
    else if (cnt_en)             idle_cnt_d = idle_cnt_q + CW'(1);
  end

  always_comb begin
    done_d = done_q;
    if (!mon_en)                    done_d = 1'b0;
    else if (start_seen)            done_d = 1'b0;
    else if (stop_seen || idle_full) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q <= 1'b1;
      scl_prev_q <= 1'b1;
      idle_cnt_q <= '0;
      done_q     <= 1'b0;
    end else begin
      sda_prev_q <= sda;
      scl_prev_q <= scl;
      idle_cnt_q <= idle_cnt_d;
      done_q     <= done_d;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/seg_line_relay.sv
module seg_line_relay
  import seg_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link,
  input  logic up_lvl,
  input  logic dn_lvl,
  output logic up_pd,
  output logic dn_pd
);

  localparam int SETTLE_CYC = SYNC_STAGES + 1;
  localparam int CW         = $clog2(SETTLE_CYC + 1);

  relay_st_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!link) begin
      st_d  = RL_FREE;
      cnt_d = '0;
    end else begin
      case (st_q)
        RL_FREE: begin
          if (!up_lvl)      st_d = RL_UPLOW;
          else if (!dn_lvl) st_d = RL_DNLOW;
        end
        RL_UPLOW: begin
          if (up_lvl) begin
            st_d  = RL_SETTLE;
            cnt_d = CW'(SETTLE_CYC);
          end
        end
        RL_DNLOW: begin
          if (dn_lvl) begin
            st_d  = RL_SETTLE;
            cnt_d = CW'(SETTLE_CYC);
          end
        end
        default: begin
          if (cnt_q <= CW'(1)) begin
            st_d  = RL_FREE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RL_FREE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign dn_pd = (st_q == RL_UPLOW);
  assign up_pd = (st_q == RL_DNLOW);

endmodule

// File: rtl/seg_link_ctrl.sv
module seg_link_ctrl
  import seg_link_pkg::*;
#(
  parameter int IDLE_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic enable,
  input  logic fault_disc,
  input  logic up_sda_i,
  input  logic up_scl_i,
  input  logic dn_sda_i,
  input  logic dn_scl_i,
  output logic up_sda_pd,
  output logic up_scl_pd,
  output logic dn_sda_pd,
  output logic dn_scl_pd,
  output logic rdy_pd
);

  localparam int NW = NUM_SIDES * NUM_LINES;

  logic [1:0]           rst_pipe_q;
  logic                 srst_n;
  logic [NW-1:0]        raw_lvl, lvl;
  logic [NUM_SIDES-1:0] side_done;
  logic [NUM_LINES-1:0] up_drv, dn_drv;
  logic                 armed, mon_en, link_q, link_d;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  // index: 0 up SDA, 1 up SCL, 2 dn SDA, 3 dn SCL
  assign raw_lvl = {dn_scl_i, dn_sda_i, up_scl_i, up_sda_i};

  seg_sync #(.W(NW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     (raw_lvl),
    .q     (lvl)
  );

  assign armed  = pwr_good && enable && !fault_disc;
  assign mon_en = armed && !link_q;

  generate
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      seg_side_mon #(.IDLE_CYCLES(IDLE_CYCLES)) u_mon (
        .clk    (clk),
        .rst_n  (srst_n),
        .mon_en (mon_en),
        .sda    (lvl[2*s]),
        .scl    (lvl[2*s+1]),
        .done   (side_done[s])
      );
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      seg_line_relay #(.SYNC_STAGES(SYNC_STAGES)) u_relay (
        .clk    (clk),
        .rst_n  (srst_n),
        .link   (link_q),
        .up_lvl (lvl[l]),
        .dn_lvl (lvl[NUM_LINES+l]),
        .up_pd  (up_drv[l]),
        .dn_pd  (dn_drv[l])
      );
    end
  endgenerate

  always_comb begin
    link_d = link_q;
    if (!armed)          link_d = 1'b0;
    else if (&side_done) link_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) link_q <= 1'b0;
    else         link_q <= link_d;
  end

  assign up_sda_pd = up_drv[0] && link_q;
  assign up_scl_pd = up_drv[1] && link_q;
  assign dn_sda_pd = dn_drv[0] && link_q;
  assign dn_scl_pd = dn_drv[1] && link_q;
  assign rdy_pd    = pwr_good && !link_q;

endmodule

// File: rtl/seg_link_ctrl_chk.sv
module seg_link_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic enable,
  input logic fault_disc,
  input logic up_sda_pd,
  input logic up_scl_pd,
  input logic dn_sda_pd,
  input logic dn_scl_pd,
  input logic rdy_pd
);

  logic any_pd;
  assign any_pd = up_sda_pd || up_scl_pd || dn_sda_pd || dn_scl_pd;

  p_uvlo_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !any_pd);

  p_uvlo_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |-> !rdy_pd);

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !any_pd);

  p_fault_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_disc && pwr_good) |=> (!any_pd && (rdy_pd || !pwr_good)));

  p_sda_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_sda_pd && dn_sda_pd));

  p_scl_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_scl_pd && dn_scl_pd));

endmodule

bind seg_link_ctrl seg_link_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .enable     (enable),
  .fault_disc (fault_disc),
  .up_sda_pd  (up_sda_pd),
  .up_scl_pd  (up_scl_pd),
  .dn_sda_pd  (dn_sda_pd),
  .dn_scl_pd  (dn_scl_pd),
  .rdy_pd     (rdy_pd)
);

// File: tb/seg_link_ctrl_tb.sv
module seg_link_ctrl_tb;

  localparam int IDLE = 16;
  localparam int JOIN_WAIT = IDLE + 10;

  logic clk = 1'b0;
  logic rst_n, pwr_good, enable, fault_disc;
  logic [3:0] ext;   // outside low drivers: 0 upSDA, 1 upSCL, 2 dnSDA, 3 dnSCL
  logic up_sda_pd, up_scl_pd, dn_sda_pd, dn_scl_pd, rdy_pd;
  logic up_sda_w, up_scl_w, dn_sda_w, dn_scl_w;
  logic [4:0] outs;
  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  assign up_sda_w = !(ext[0] || up_sda_pd);
  assign up_scl_w = !(ext[1] || up_scl_pd);
  assign dn_sda_w = !(ext[2] || dn_sda_pd);
  assign dn_scl_w = !(ext[3] || dn_scl_pd);
  assign outs = {rdy_pd, dn_scl_pd, dn_sda_pd, up_scl_pd, up_sda_pd};

  seg_link_ctrl #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .enable(enable),
    .fault_disc(fault_disc),
    .up_sda_i(up_sda_w), .up_scl_i(up_scl_w),
    .dn_sda_i(dn_sda_w), .dn_scl_i(dn_scl_w),
    .up_sda_pd(up_sda_pd), .up_scl_pd(up_scl_pd),
    .dn_sda_pd(dn_sda_pd), .dn_scl_pd(dn_scl_pd), .rdy_pd(rdy_pd)
  );

  task automatic chk(input string req, input logic [4:0] exp);
    n_chk++;
    if (outs !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs {rdy,dnSCL,dnSDA,upSCL,upSDA} = %b, expected %b", req, outs, exp);
    end
  endtask

  task automatic chk_wires(input string req);
    n_chk++;
    if ({dn_scl_w, dn_sda_w, up_scl_w, up_sda_w} !== 4'b1111) begin
      n_bad++;
      $display("FAIL %s: wires = %b, expected 1111",
               req, {dn_scl_w, dn_sda_w, up_scl_w, up_sda_w});
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0; enable = 1'b0; fault_disc = 1'b0; ext = '0;
    cyc(3);
    chk("R1 reset", 5'b00000);
    rst_n = 1'b1;
    enable = 1'b1;
    // R1: lockout ignores every line
    for (int k = 0; k < 4; k++) begin
      ext[k] = 1'b1; cyc(8);
      chk("R1 lockout line activity", 5'b00000);
      ext[k] = 1'b0;
    end
    cyc(JOIN_WAIT);
    chk("R1 lockout idle", 5'b00000);

    // R4: enable low, powered
    pwr_good = 1'b1; enable = 1'b0;
    cyc(JOIN_WAIT);
    chk("R4 disabled no join / R3 ready low", 5'b10000);
    for (int k = 0; k < 4; k++) begin
      ext[k] = 1'b1; cyc(8);
      chk("R4 disabled no copy", 5'b10000);
      ext[k] = 1'b0;
    end

    // R2 idle route: a held side never counts as idle
    ext[1] = 1'b1; enable = 1'b1;
    cyc(JOIN_WAIT);
    chk("R2 held side blocks join", 5'b10000);
    ext[1] = 1'b0;
    cyc(JOIN_WAIT);
    chk("R2 idle join / R3 ready released", 5'b00000);

    enable = 1'b0; cyc(3);
    chk("R4 drop enable", 5'b10000);

    // R2 STOP route
    ext[0] = 1'b1; enable = 1'b1;
    cyc(JOIN_WAIT);
    chk("R2 no join before STOP", 5'b10000);
    ext[0] = 1'b0;
    cyc(6);
    chk("R2 STOP join", 5'b00000);

    // R5 / R8 sweep over every line and direction
    for (int k = 0; k < 4; k++) begin
      ext[k] = 1'b1; cyc(6);
      chk("R5 copy low to opposite side", 5'(1 << (k ^ 2)));
      ext[k] = 1'b0; cyc(12);
      chk("R8 no self-latch after release", 5'b00000);
      chk_wires("R8 wires high after release");
    end

    // R6 clock stretching across the boundary
    ext[1] = 1'b1; cyc(6);
    chk("R6 upstream SCL low copied", 5'b01000);
    ext[3] = 1'b1; cyc(4);
    ext[1] = 1'b0; cyc(15);
    chk("R6 upstream held while downstream stretches", 5'b00010);
    n_chk++;
    if (up_scl_w !== 1'b0) begin
      n_bad++;
      $display("FAIL R6: upstream SCL wire = %b, expected 0", up_scl_w);
    end
    ext[3] = 1'b0; cyc(15);
    chk("R6 full release", 5'b00000);
    chk_wires("R6 both sides high");

    // R7 fault disconnect
    ext[0] = 1'b1; cyc(6);
    chk("R7 pre-fault copy", 5'b00100);
    fault_disc = 1'b1; cyc(2);
    chk("R7 fault drop", 5'b10000);
    cyc(JOIN_WAIT);
    chk("R7 stays apart during fault", 5'b10000);
    ext[0] = 1'b0; fault_disc = 1'b0;
    cyc(JOIN_WAIT);
    chk("R7 rejoin after fault", 5'b00000);

    // R4 enable drop while copying
    ext[2] = 1'b1; cyc(6);
    chk("R5 downstream SDA copied", 5'b00001);
    enable = 1'b0; cyc(2);
    chk("R4 enable drop releases", 5'b10000);
    ext[2] = 1'b0; enable = 1'b1;
    cyc(JOIN_WAIT);
    chk("R4 rejoin after enable", 5'b00000);

    // R1 power loss while joined
    pwr_good = 1'b0; cyc(2);
    chk("R1 power loss", 5'b00000);
    ext[0] = 1'b1; cyc(6);
    chk("R1 power loss ignores lines", 5'b00000);
    ext[0] = 1'b0;

    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule